// File: doc/BRIEF.md
# Long-Press Reset Delay Timer

This block turns a deliberate, sustained two-button press into a single system reset pulse. Two active-low button lines are synchronized to the block clock. Timing starts only while both are low at once. If the press is held without a break for the selected long delay, the block drives an active-low and an active-high reset output together for a fixed recovery period. It then releases them. A release of either button before the delay ends restarts the timing silently, so a brief or one-handed press never resets the system.

Timing comes from two counter stages. A prescaler divides the clock down to a tick. A delay stage counts ticks, first up to the selected delay and then up to the recovery length. All terminal counts are worked out at elaboration from the clock and tick frequency parameters. The defaults give an 8-bit prescaler and a 13-bit delay stage. A test pin, when high, bypasses the prescaler so that the delay stage advances on every clock.

Top module: `lp_reset_timer`

## Requirements
- R1: The delay is chosen by `dly_sel`: value 0 gives 3000 ms, 1 gives 3750 ms, 2 gives 4500 ms and 3 gives 6000 ms. Each is converted to ticks as ms*TICK_HZ/1000.
- R2: Timing runs only while both button lines are low together. Holding just one of them low never produces a pulse.
- R3: If either button line goes high before the delay expires, no output changes and the timing clears. The next press needs the full delay again, and a single high clock cycle is enough to clear it.
- R4: With both buttons first sampled low at clock edge 1, the outputs switch together at edge 3 + T*P. Here T is the delay in ticks and P = CLK_HZ/TICK_HZ. `rst_out_n` goes low and `rst_out` goes high, and they stay complementary at all times. A press held for T*P+1 cycles gives a pulse; a press held for T*P cycles does not.
- R5: The outputs stay asserted for exactly REC*P cycles, with REC = 400*TICK_HZ/1000, and then return to idle. This holds even if the buttons are released during the pulse.
- R6: The prescaler emits one tick every P clocks. The delay stage counts only those ticks and never reaches its current limit.
- R7: `dly_sel` is sampled only when timing starts and is held until the block is idle again. A change during a press does not change that press's delay.
- R8: With `test_mode` low, timing is as in R4. With `test_mode` high, the prescaler is bypassed: the switch happens at edge 3 + T and the pulse lasts REC cycles.
- R9: Holding both buttons down past the pulse gives exactly one pulse. A new press is accepted only after at least one button has been seen high once the pulse has ended.
- R10: While `rst` is high at a clock edge, the block returns to idle: `rst_out_n` is high, `rst_out` is low and the counters are cleared, including in the middle of a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| btn_a_n | input | 1 | First button line, active low, asynchronous |
| btn_b_n | input | 1 | Second button line, active low, asynchronous |
| dly_sel | input | 2 | Delay choice, static during operation |
| test_mode | input | 1 | Low in normal use; high bypasses the prescaler |
| rst_out_n | output | 1 | Active-low reset output |
| rst_out | output | 1 | Active-high reset output |

## Verification
The sharpest collision is a button release landing in the same cycle as the last prescaled tick of the delay. The delay stage would then report expiry just as the synchronized inputs stop showing a double press. The bench provokes this by holding the press for exactly T*P and for T*P+1 cycles. It expects no pulse in the first case and a pulse at edge 3 + T*P in the second. A second pairing, a release or a reset that arrives during the recovery pulse, is judged by checking that the pulse width stays fixed and that reset drops both outputs to idle on the next sample.

// File: rtl/lprt_pkg.sv
package lprt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_PULSE = 2'd2,
        ST_HOLD  = 2'd3
    } lprt_state_e;

    typedef struct packed {
        logic rst_n;
        logic rst;
    } lprt_out_s;

    localparam int unsigned REC_MS = 400;

    function automatic int unsigned sel_ms(input logic [1:0] code);
        case (code)
            2'd0:    return 3000;
            2'd1:    return 3750;
            2'd2:    return 4500;
            default: return 6000;
        endcase
    endfunction

    function automatic int unsigned ms_ticks(input int unsigned ms, input int unsigned hz);
        return (ms * hz) / 1000;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/lprt_sync.sv
module lprt_sync #(
    parameter int unsigned WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] q_out
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic s1_q, s2_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                s1_q <= 1'b1;
                s2_q <= 1'b1;
            end else begin
                s1_q <= d_in[g];
                s2_q <= s1_q;
            end
        end
        assign q_out[g] = s2_q;
    end
endmodule

// File: rtl/lprt_prescaler.sv
module lprt_prescaler #(
    parameter int unsigned DIV = 256,
    localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic bypass,
    output logic tick
);
    logic [PW-1:0] cnt_q;

    assign tick = en & (bypass | (cnt_q == PW'(DIV - 1)));

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assert_pre_bound_R6: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= PW'(DIV - 1));

    assert_pre_idle_clear_R6: assert property (@(posedge clk) disable iff (rst)
        !en |=> (cnt_q == '0));
endmodule

// File: rtl/lprt_delay_ctr.sv
module lprt_delay_ctr #(
    parameter int unsigned DW = 13
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          tick,
    input  logic [DW-1:0] limit,
    output logic          done
);
    logic [DW-1:0] cnt_q;

    assign done = tick & (cnt_q == limit - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= done ? '0 : cnt_q + 1'b1;
        end
    end

    assert_cnt_below_limit_R6: assert property (@(posedge clk) disable iff (rst)
        en |-> (cnt_q < limit));

    assert_cnt_holds_without_tick_R6: assert property (@(posedge clk) disable iff (rst)
        (en && !tick) |=> $stable(cnt_q));
endmodule

// File: rtl/lprt_fsm.sv
module lprt_fsm
    import lprt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        both_low,
    input  logic        done,
    input  logic [1:0]  sel_in,
    output lprt_state_e state,
    output logic [1:0]  sel_q
);
    lprt_state_e state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            sel_q   <= 2'd0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (both_low) begin
                        state_q <= ST_COUNT;
                        sel_q   <= sel_in;
                    end
                end
                ST_COUNT: begin
                    if (!both_low)  state_q <= ST_IDLE;
                    else if (done)  state_q <= ST_PULSE;
                end
                ST_PULSE: begin
                    if (done) state_q <= ST_HOLD;
                end
                default: begin
                    if (!both_low) state_q <= ST_IDLE;
                end
            endcase
        end
    end

    assign state = state_q;

    assert_pulse_needs_press_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(state_q == ST_PULSE) |-> $past(both_low));

    assert_abort_idle_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_COUNT && !both_low) |=> (state_q == ST_IDLE));

    assert_pulse_exit_R5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PULSE) |=> (state_q == ST_PULSE || state_q == ST_HOLD));

    assert_sel_frozen_R7: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE) |=> $stable(sel_q));

    assert_single_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HOLD && both_low) |=> (state_q == ST_HOLD));
endmodule

// File: rtl/lp_reset_timer.sv
module lp_reset_timer
    import lprt_pkg::*;
#(
    parameter int unsigned CLK_HZ  = 262144,
    parameter int unsigned TICK_HZ = 1024
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       btn_a_n,
    input  logic       btn_b_n,
    input  logic [1:0] dly_sel,
    input  logic       test_mode,
    output logic       rst_out_n,
    output logic       rst_out
);
    localparam int unsigned PRE_DIV = (CLK_HZ / TICK_HZ > 0) ? CLK_HZ / TICK_HZ : 1;
    localparam int unsigned T_REC   = ms_ticks(REC_MS, TICK_HZ);
    localparam int unsigned T_MAX   = max2(max2(ms_ticks(sel_ms(2'd0), TICK_HZ),
                                                ms_ticks(sel_ms(2'd1), TICK_HZ)),
                                           max2(max2(ms_ticks(sel_ms(2'd2), TICK_HZ),
                                                     ms_ticks(sel_ms(2'd3), TICK_HZ)),
                                                T_REC));
    localparam int unsigned DLY_W   = $clog2(T_MAX + 1);

    logic [1:0]       btn_sync;
    logic             both_low;
    logic             cnt_en;
    logic             tick;
    logic             done;
    logic [DLY_W-1:0] limit;
    logic [1:0]       sel_q;
    lprt_state_e      state;
    lprt_out_s        outs;
    logic [DLY_W-1:0] term_tab [4];

    for (genvar g = 0; g < 4; g++) begin : g_term
        assign term_tab[g] = DLY_W'(ms_ticks(sel_ms(2'(g)), TICK_HZ));
    end

    lprt_sync #(.WIDTH(2)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .d_in  ({btn_a_n, btn_b_n}),
        .q_out (btn_sync)
    );

    assign both_low = (btn_sync == 2'b00);
    assign cnt_en   = (state == ST_COUNT) || (state == ST_PULSE);
    assign limit    = (state == ST_PULSE) ? DLY_W'(T_REC) : term_tab[sel_q];

    lprt_prescaler #(.DIV(PRE_DIV)) u_pre (
        .clk    (clk),
        .rst    (rst),
        .en     (cnt_en),
        .bypass (test_mode),
        .tick   (tick)
    );

    lprt_delay_ctr #(.DW(DLY_W)) u_dly (
        .clk   (clk),
        .rst   (rst),
        .en    (cnt_en),
        .tick  (tick),
        .limit (limit),
        .done  (done)
    );

    lprt_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .both_low (both_low),
        .done     (done),
        .sel_in   (dly_sel),
        .state    (state),
        .sel_q    (sel_q)
    );

    always_comb begin
        outs = '{rst_n: 1'b1, rst: 1'b0};
        if (state == ST_PULSE) outs = '{rst_n: 1'b0, rst: 1'b1};
    end

    assign rst_out_n = outs.rst_n;
    assign rst_out   = outs.rst;

    assert_idle_after_reset_R10: assert property (@(posedge clk)
        $past(rst) |-> (rst_out_n && !rst_out));
endmodule

// File: tb/test_lp_reset_timer.sv
module test_lp_reset_timer;
    localparam int unsigned CLK_HZ  = 1000;
    localparam int unsigned TICK_HZ = 100;
    localparam int          PDIV    = CLK_HZ / TICK_HZ;
    localparam int          REC_T   = 400 * TICK_HZ / 1000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       btn_a_n = 1'b1;
    logic       btn_b_n = 1'b1;
    logic [1:0] dly_sel = 2'd0;
    logic       test_mode = 1'b0;
    logic       rst_out_n;
    logic       rst_out;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    lp_reset_timer #(.CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ)) i_lp_reset_timer (
        .clk       (clk),
        .rst       (rst),
        .btn_a_n   (btn_a_n),
        .btn_b_n   (btn_b_n),
        .dly_sel   (dly_sel),
        .test_mode (test_mode),
        .rst_out_n (rst_out_n),
        .rst_out   (rst_out)
    );

    function automatic int sel_ticks(input logic [1:0] s);
        int ms;
        case (s)
            2'd0: ms = 3000;
            2'd1: ms = 3750;
            2'd2: ms = 4500;
            default: ms = 6000;
        endcase
        return ms * TICK_HZ / 1000;
    endfunction

    function automatic int per(input logic tm);
        return tm ? 1 : PDIV;
    endfunction

    function automatic int exp_lat(input logic [1:0] s, input logic tm);
        return 3 + sel_ticks(s) * per(tm);
    endfunction

    function automatic int exp_width(input logic tm);
        return REC_T * per(tm);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // press both (or one) buttons, hold for 'hold' cycles, observe 'span' samples
    task automatic run_press(input logic [1:0] sel, input logic tm, input bit use_a,
                             input bit use_b, input int hold, input int span,
                             input int chg_at, input logic [1:0] sel2, input int gap,
                             output int lat, output int width, output int bad_pair);
        lat = 0; width = 0; bad_pair = 0;
        @(negedge clk);
        dly_sel = sel; test_mode = tm;
        btn_a_n = !use_a; btn_b_n = !use_b;
        for (int n = 1; n <= span; n++) begin
            @(negedge clk);
            if (rst_out_n !== ~rst_out) bad_pair++;
            if (rst_out === 1'b1) begin
                if (lat == 0) lat = n;
                width++;
            end
            if (n == chg_at) dly_sel = sel2;
            if (n == hold) begin btn_a_n = 1'b1; btn_b_n = 1'b1; end
        end
        btn_a_n = 1'b1; btn_b_n = 1'b1;
        for (int k = 0; k < gap; k++) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int lat, w, bp, tp, hold, span, el, ew;
        logic [1:0] s;
        logic tm;
        void'($urandom(32'd5173));

        repeat (3) @(negedge clk);
        chk(rst_out_n === 1'b1 && rst_out === 1'b0, "R10 reset idle", rst_out, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // R4/R5/R9: held far past the pulse, one pulse only
        span = exp_lat(0, 0) + exp_width(0) + 3000;
        run_press(0, 0, 1, 1, span + 1, span, 0, 0, 4, lat, w, bp);
        chk(lat == exp_lat(0, 0), "R4 latency sel0", lat, exp_lat(0, 0));
        chk(w == exp_width(0), "R5/R9 single pulse width", w, exp_width(0));
        chk(bp == 0, "R4 outputs complementary", bp, 0);
        // R9 re-arm after release
        run_press(0, 0, 1, 1, 4000, 3500, 0, 0, 4, lat, w, bp);
        chk(lat == exp_lat(0, 0), "R9 re-arm latency", lat, exp_lat(0, 0));

        // R1 other codes
        for (int c = 1; c < 4; c++) begin
            span = exp_lat(2'(c), 0) + exp_width(0) + 10;
            run_press(2'(c), 0, 1, 1, span + 1, span, 0, 0, 4, lat, w, bp);
            chk(lat == exp_lat(2'(c), 0), "R1 delay code", lat, exp_lat(2'(c), 0));
        end

        // R3/R4 boundary: T*P vs T*P+1 hold
        tp = sel_ticks(0) * PDIV;
        run_press(0, 0, 1, 1, tp, 3500, 0, 0, 4, lat, w, bp);
        chk(lat == 0, "R3 release at expiry cycle no pulse", lat, 0);
        run_press(0, 0, 1, 1, tp + 1, 3500, 0, 0, 4, lat, w, bp);
        chk(lat == exp_lat(0, 0), "R4 hold T*P+1 pulses", lat, exp_lat(0, 0));
        chk(w == exp_width(0), "R5 width after early release", w, exp_width(0));

        // R2 single button
        run_press(0, 0, 1, 0, 3500, 3500, 0, 0, 4, lat, w, bp);
        chk(lat == 0, "R2 only first button", lat, 0);
        run_press(0, 0, 0, 1, 3500, 3500, 0, 0, 4, lat, w, bp);
        chk(lat == 0, "R2 only second button", lat, 0);

        // R3 one-cycle release clears timing
        run_press(0, 0, 1, 1, 1500, 1500, 0, 0, 0, lat, w, bp);
        chk(lat == 0, "R3 short press no pulse", lat, 0);
        run_press(0, 0, 1, 1, 4000, 3500, 0, 0, 4, lat, w, bp);
        chk(lat == exp_lat(0, 0), "R3 full delay after glitch", lat, exp_lat(0, 0));

        // R7 select change during press ignored
        run_press(0, 0, 1, 1, 4000, 3500, 20, 3, 4, lat, w, bp);
        chk(lat == exp_lat(0, 0), "R7 select latched", lat, exp_lat(0, 0));

        // R8 test mode bypass
        run_press(3, 1, 1, 1, 800, 700, 0, 0, 4, lat, w, bp);
        chk(lat == exp_lat(3, 1), "R8 test latency", lat, exp_lat(3, 1));
        chk(w == exp_width(1), "R8 test width", w, exp_width(1));

        // R10 reset in the middle of a pulse
        @(negedge clk);
        dly_sel = 0; test_mode = 1; btn_a_n = 0; btn_b_n = 0;
        repeat (exp_lat(0, 1) + 5) @(negedge clk);
        chk(rst_out === 1'b1, "R10 pulse active before reset", rst_out, 1);
        rst = 1'b1;
        @(negedge clk);
        chk(rst_out === 1'b0 && rst_out_n === 1'b1, "R10 reset mid pulse", rst_out, 0);
        rst = 1'b0; btn_a_n = 1; btn_b_n = 1; test_mode = 0;
        repeat (4) @(negedge clk);

        // random presses
        for (int i = 0; i < 8; i++) begin
            s  = 2'($urandom % 4);
            tm = ($urandom % 3) == 0;
            tp = sel_ticks(s) * per(tm);
            if ($urandom % 2) hold = int'($urandom % tp) + 1;
            else hold = tp + 1 + int'($urandom % (exp_width(tm) + 50));
            span = exp_lat(s, tm) + exp_width(tm) + 10;
            el = (hold >= tp + 1) ? exp_lat(s, tm) : 0;
            ew = (hold >= tp + 1) ? exp_width(tm) : 0;
            run_press(s, tm, 1, 1, hold, span, 0, 0, 4, lat, w, bp);
            chk(lat == el, "R4/R3 random latency", lat, el);
            chk(w == ew, "R5 random width", w, ew);
            chk(bp == 0, "R4 random complement", bp, 0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule